// File: doc/BRIEF.md
# INTx Virtual Wire Aggregator

This block sits on the upstream side of a switch. It collects the legacy INTA..INTD interrupt levels from two downstream ports and folds them onto the four interrupt lines of the upstream port. For each downstream port, the level of an interrupt wire is the OR of two sources: the level received over that port's link, and the level the port raises for itself. A port whose link is down contributes nothing.

The wires of the second downstream port are rotated by two positions before they are merged, following the device-number swizzle of a bridge. The wires of the first port are merged without change. Each upstream line carries the OR of every source mapped onto it.

The block remembers, for each upstream line, the last level it reported. When the current aggregate of a line differs from that reported level, the block raises a request for an assert or a deassert message. A request is presented on a valid/ready handshake and held until it is accepted. If the line goes back to its reported level before the request is accepted, the request is withdrawn. When more than one line is pending, the requests are issued one at a time, lowest line first.

Top module: `intx_vwire_agg`

## Requirements
- R1: For each downstream port, a wire is active when its received level or its locally raised level is 1.
- R2: The wires of port 0 map straight onto the upstream lines: wire k drives upstream line k.
- R3: The wires of port 1 are rotated: its wires INTC, INTD, INTA and INTB (indices 2, 3, 0, 1) drive upstream lines 0, 1, 2 and 3.
- R4: Each upstream line is the OR of all mapped sources. Once the inputs have been stable and ready has been held high, the levels reported through accepted messages equal that OR.
- R5: An accepted request with msg_assert_o=1 is issued only for a line whose reported level was 0, and it sets that level to 1.
- R6: An accepted request with msg_assert_o=0 is issued only for a line whose reported level was 1, and it clears that level to 0.
- R7: While link_up_i[p]=0, every wire of port p counts as negated. A line asserted only by that port is then deasserted.
- R8: When several lines are pending at once, requests are issued in increasing line index. The line index is encoded as 0=INTA, 1=INTB, 2=INTC, 3=INTD.
- R9: While msg_ready_i=0 and the pending line still differs from its reported level, msg_valid_o stays 1, and msg_line_o and msg_assert_o stay unchanged.
- R10: If the line of an unaccepted request returns to its reported level, the request is withdrawn and no message is issued for it.
- R11: After reset, all reported levels are 0 and msg_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_int_i | input | 8 | Received INTx levels; bits [4p+3:4p] belong to port p, with bit 0 of each group being INTA |
| loc_int_i | input | 8 | Locally raised INTx levels, same layout as ext_int_i |
| link_up_i | input | 2 | Link-up status, one bit per downstream port |
| msg_valid_o | output | 1 | A message request is presented |
| msg_ready_i | input | 1 | The consumer accepts the presented request |
| msg_assert_o | output | 1 | 1 = assert message, 0 = deassert message |
| msg_line_o | output | 2 | Upstream line index, 0=INTA to 3=INTD |

## Verification
The hardest case to produce is a request that is withdrawn. It needs a line to change level and then change back while the consumer is holding ready low. The stimulus stalls ready, raises one source, checks that the request is presented and held, and then drops the source. It then checks that the request disappears and that no message appears once ready returns. Priority ordering is reached the same way: several lines are raised behind a stalled ready, and the issue order is checked after the stall is released.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;
  localparam int unsigned INTX_LINES = 4;
  typedef enum logic {
    MSG_DEASSERT = 1'b0,
    MSG_ASSERT   = 1'b1
  } msg_kind_e;
endpackage

// File: rtl/intx_rst_sync.sv
module intx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/intx_port_map.sv
module intx_port_map #(
  parameter int unsigned LINES  = 4,
  parameter int unsigned OFFSET = 0
) (
  input  logic [LINES-1:0] ext_i,
  input  logic [LINES-1:0] loc_i,
  input  logic             link_up_i,
  output logic [LINES-1:0] mapped_o
);
  logic [LINES-1:0] wire_lvl;

  assign wire_lvl = (ext_i | loc_i) & {LINES{link_up_i}};

  for (genvar j = 0; j < LINES; j++) begin : g_rot
    localparam int unsigned SRC = (j + OFFSET) % LINES;
    assign mapped_o[j] = wire_lvl[SRC];
  end
endmodule

// File: rtl/intx_msg_sched.sv
module intx_msg_sched #(
  parameter int unsigned LINES = 4,
  localparam int unsigned IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] agg_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IW-1:0]    line_o,
  output logic             assert_o,
  output logic [LINES-1:0] rpt_o
);
  logic             vld_q, vld_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             typ_q, typ_d;
  logic [LINES-1:0] rpt_q, rpt_d;
  logic [LINES-1:0] pend;
  logic [IW-1:0]    sel;
  logic             found;
  logic             fire;
  logic             keep;

  assign fire = vld_q & ready_i;

  always_comb begin
    rpt_d = rpt_q;
    if (fire) rpt_d[idx_q] = typ_q;
  end

  assign pend = agg_i ^ rpt_d;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign keep = vld_q & ~fire & (agg_i[idx_q] != rpt_q[idx_q]);

  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    typ_d = typ_q;
    if (keep) begin
      vld_d = 1'b1;
    end else if (found) begin
      vld_d = 1'b1;
      idx_d = sel;
      typ_d = agg_i[sel];
    end else begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      typ_q <= intx_agg_pkg::MSG_DEASSERT;
      rpt_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
      typ_q <= typ_d;
      rpt_q <= rpt_d;
    end
  end

  assign valid_o  = vld_q;
  assign line_o   = idx_q;
  assign assert_o = typ_q;
  assign rpt_o    = rpt_q;
endmodule

// File: rtl/intx_vwire_agg.sv
module intx_vwire_agg #(
  parameter int unsigned PORTS   = 2,
  parameter int unsigned LINES   = intx_agg_pkg::INTX_LINES,
  parameter int unsigned SWZ_STEP = 2,
  localparam int unsigned IW     = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS*LINES-1:0] ext_int_i,
  input  logic [PORTS*LINES-1:0] loc_int_i,
  input  logic [PORTS-1:0]       link_up_i,
  output logic                   msg_valid_o,
  input  logic                   msg_ready_i,
  output logic                   msg_assert_o,
  output logic [IW-1:0]          msg_line_o
);
  logic             rst_core_n;
  logic [LINES-1:0] mapped [PORTS];
  logic [LINES-1:0] agg_w;
  logic [LINES-1:0] rpt_w;

  intx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    intx_port_map #(
      .LINES  (LINES),
      .OFFSET ((p * SWZ_STEP) % LINES)
    ) u_map (
      .ext_i     (ext_int_i[p*LINES +: LINES]),
      .loc_i     (loc_int_i[p*LINES +: LINES]),
      .link_up_i (link_up_i[p]),
      .mapped_o  (mapped[p])
    );
  end

  always_comb begin
    agg_w = '0;
    for (int p = 0; p < PORTS; p++) agg_w = agg_w | mapped[p];
  end

  intx_msg_sched #(.LINES(LINES)) u_sched (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .agg_i    (agg_w),
    .ready_i  (msg_ready_i),
    .valid_o  (msg_valid_o),
    .line_o   (msg_line_o),
    .assert_o (msg_assert_o),
    .rpt_o    (rpt_w)
  );
endmodule

// File: rtl/intx_vwire_agg_chk.sv
module intx_vwire_agg_chk #(
  parameter int unsigned PORTS = 2,
  parameter int unsigned LINES = 4,
  parameter int unsigned IW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PORTS-1:0] link_up_i,
  input logic [LINES-1:0] agg_w,
  input logic [LINES-1:0] rpt_w,
  input logic             msg_valid_o,
  input logic             msg_ready_i,
  input logic             msg_assert_o,
  input logic [IW-1:0]    msg_line_o
);
  assert_real_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> (rpt_w[msg_line_o] != msg_assert_o));

  assert_report_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && msg_ready_i) |=> (rpt_w[$past(msg_line_o)] == $past(msg_assert_o)));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i && (agg_w[msg_line_o] != rpt_w[msg_line_o]))
      |=> (msg_valid_o && $stable(msg_line_o) && $stable(msg_assert_o)));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid_o && (agg_w == rpt_w)) |=> !msg_valid_o);

  assert_link_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_i == '0) |-> (agg_w == '0));
endmodule

bind intx_vwire_agg intx_vwire_agg_chk #(
  .PORTS (PORTS),
  .LINES (LINES),
  .IW    (IW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_up_i    (link_up_i),
  .agg_w        (agg_w),
  .rpt_w        (rpt_w),
  .msg_valid_o  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .msg_assert_o (msg_assert_o),
  .msg_line_o   (msg_line_o)
);

// File: tb/intx_vwire_agg_tb.sv
module intx_vwire_agg_tb;
  logic       clk;
  logic       rst_n;
  logic [7:0] ext_int_i;
  logic [7:0] loc_int_i;
  logic [1:0] link_up_i;
  logic       msg_valid_o;
  logic       msg_ready_i;
  logic       msg_assert_o;
  logic [1:0] msg_line_o;

  int total;
  int bad;
  int nmsg;
  int last_idx;
  logic [3:0] brpt;
  logic [31:0] lfsr;

  intx_vwire_agg u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_int_i    (ext_int_i),
    .loc_int_i    (loc_int_i),
    .link_up_i    (link_up_i),
    .msg_valid_o  (msg_valid_o),
    .msg_ready_i  (msg_ready_i),
    .msg_assert_o (msg_assert_o),
    .msg_line_o   (msg_line_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_agg(input logic [7:0] e, input logic [7:0] l,
                                         input logic [1:0] u);
    logic [3:0] p0, p1;
    p0 = (e[3:0] | l[3:0]) & {4{u[0]}};
    p1 = (e[7:4] | l[7:4]) & {4{u[1]}};
    return {p0[3] | p1[1], p0[2] | p1[0], p0[1] | p1[3], p0[0] | p1[2]};
  endfunction

  always @(negedge clk) begin
    if (rst_n && msg_valid_o && msg_ready_i) begin
      if (msg_assert_o) check(brpt[msg_line_o] == 1'b0, "R5 assert on low line", brpt[msg_line_o], 0);
      else              check(brpt[msg_line_o] == 1'b1, "R6 deassert on high line", brpt[msg_line_o], 1);
      check(int'(msg_line_o) > last_idx, "R8 increasing order", msg_line_o, last_idx + 1);
      brpt[msg_line_o] = msg_assert_o;
      last_idx = int'(msg_line_o);
      nmsg++;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic apply(input logic [7:0] e, input logic [7:0] l, input logic [1:0] u);
    @(posedge clk);
    #1;
    ext_int_i = e;
    loc_int_i = l;
    link_up_i = u;
    last_idx  = -1;
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    logic [3:0] ea;
    total = 0; bad = 0; nmsg = 0; last_idx = -1; brpt = '0;
    rst_n = 1'b0;
    ext_int_i = '0; loc_int_i = '0; link_up_i = 2'b11; msg_ready_i = 1'b1;
    lfsr = 32'hACE1_2345;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check(msg_valid_o == 1'b0, "R11 idle after reset", msg_valid_o, 0);
    tick(4);
    check(nmsg == 0, "R11 no messages after reset", nmsg, 0);

    // R3: port 1 INTA feeds upstream INTC
    n0 = nmsg;
    apply(8'h00, 8'h10, 2'b11);
    tick(6);
    check(nmsg == n0 + 1, "R3 one message", nmsg, n0 + 1);
    check(brpt == 4'b0100, "R3 port1 INTA to line 2", brpt, 4'b0100);

    // R2 and R1: port 0 received INTB feeds line 1
    apply(8'h02, 8'h10, 2'b11);
    tick(6);
    check(brpt == 4'b0110, "R2 port0 INTB to line 1", brpt, 4'b0110);

    // R7: link 1 down drops line 2
    apply(8'h02, 8'h10, 2'b01);
    tick(6);
    check(brpt == 4'b0010, "R7 link down deasserts", brpt, 4'b0010);
    apply(8'h00, 8'h00, 2'b11);
    tick(6);
    check(brpt == 4'b0000, "R6 all clear", brpt, 0);

    // R8 and R9: stall, raise all four, then release
    msg_ready_i = 1'b0;
    apply(8'h0F, 8'h00, 2'b11);
    tick(3);
    check(msg_valid_o && msg_line_o == 2'd0, "R8 lowest line first", msg_line_o, 0);
    tick(5);
    check(msg_valid_o && msg_line_o == 2'd0 && msg_assert_o, "R9 held while stalled", msg_line_o, 0);
    n0 = nmsg;
    msg_ready_i = 1'b1;
    tick(8);
    check(nmsg == n0 + 4, "R8 four messages issued", nmsg, n0 + 4);
    check(brpt == 4'hF, "R8 all lines reported", brpt, 15);
    apply(8'h00, 8'h00, 2'b11);
    tick(8);

    // R10: withdraw a request before acceptance
    msg_ready_i = 1'b0;
    apply(8'h08, 8'h00, 2'b11);
    tick(3);
    check(msg_valid_o && msg_line_o == 2'd3, "R10 request presented", msg_line_o, 3);
    apply(8'h00, 8'h00, 2'b11);
    tick(3);
    check(msg_valid_o == 1'b0, "R10 request withdrawn", msg_valid_o, 0);
    n0 = nmsg;
    msg_ready_i = 1'b1;
    tick(6);
    check(nmsg == n0, "R10 no message after withdraw", nmsg, n0);

    // R1 R4: pseudo-random sweep of all source combinations
    for (int v = 0; v < 2500; v++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[7:0] & lfsr[15:8], lfsr[23:16] & lfsr[31:24],
            (lfsr[3:2] == 2'b00) ? 2'b10 : ((lfsr[5:4] == 2'b00) ? 2'b01 : 2'b11));
      tick(8);
      ea = exp_agg(ext_int_i, loc_int_i, link_up_i);
      check(brpt == ea, "R4 R1 aggregate reported", brpt, ea);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule